// File: doc/BRIEF.md
# Hamming single-error-correcting memory word codec

This block protects one byte of memory data with a Hamming code. On the write side, a combinational encoder turns the byte into a 12-bit codeword. Four check bits sit at the power-of-two positions and the eight data bits fill the remaining positions. When the `USE_DED` parameter is set (the default), a thirteenth bit holding the even parity of the whole word is appended, so that double errors can be detected.

On the read side, the stored codeword comes back with a one-cycle strobe. The checker recomputes the check bits from the fetched data and XORs them with the stored check bits to form a 4-bit syndrome. From the syndrome, and the overall parity when enabled, it makes one of four decisions:

- the word is clean;
- one data bit flipped and is corrected;
- only a check bit was hit;
- the error cannot be corrected.

The decision and the output byte appear on registers one clock after the strobe and hold until the next strobe.

Top module: `hamSecCodec`

## Requirements
- R1: Codeword bit index is position minus one. Check bits occupy positions 1, 2, 4 and 8 (bits 0, 1, 3, 7). Data bits wrData[0..7] occupy positions 3, 5, 6, 7, 9, 10, 11 and 12 (bits 2, 4, 5, 6, 8, 9, 10, 11), in that order.
- R2: Each check bit is the XOR of the data bits whose position has a 1 in that check bit's weight. With M1..M8 = wrData[0..7]: pos1 = M1^M2^M4^M5^M7, pos2 = M1^M3^M4^M6^M7, pos4 = M2^M3^M4^M8, pos8 = M5^M6^M7^M8. With USE_DED, bit 12 (position 13) makes the XOR of all 13 bits zero.
- R3: rdDone rises exactly one clock after a cycle with rdValid high and is low otherwise. rdData and the four flags change only on that edge and hold their values while rdValid is low, whatever rdCode does.
- R4: A zero syndrome with correct overall parity sets noError, and rdData equals the fetched data bits.
- R5: A syndrome with two or more bits set and a value of 12 or less, with odd overall parity in DED mode, sets corrected. The data bit at that position is inverted, so any single flipped data bit is restored.
- R6: A syndrome with exactly one bit set and odd overall parity, or a zero syndrome with odd overall parity in DED mode (the parity bit itself flipped), sets checkFault. rdData equals the fetched data bits, uncorrected.
- R7: In DED mode, a nonzero syndrome with even overall parity (for example two flipped bits) sets uncorrectable. rdData equals the fetched data bits, uncorrected.
- R8: A syndrome value of 13, 14 or 15 sets uncorrectable and no data bit is inverted.
- R9: Every result has exactly one of noError, corrected, checkFault and uncorrectable set.
- R10: While rstN is low, rdDone, rdData and all four flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrData | input | 8 | Data byte to encode |
| wrCode | output | 12 + USE_DED (13) | Codeword built from wrData, combinational |
| rdValid | input | 1 | Strobe: rdCode holds a fetched codeword this cycle |
| rdCode | input | 12 + USE_DED (13) | Fetched codeword to check |
| rdData | output | 8 | Registered data byte, corrected when possible |
| rdDone | output | 1 | One-cycle pulse marking a new result |
| noError | output | 1 | Result: clean word |
| corrected | output | 1 | Result: one data bit inverted |
| checkFault | output | 1 | Result: only a check or parity bit was wrong |
| uncorrectable | output | 1 | Result: error beyond single correction |

## Verification
The properties assume that every input is at a known level from the first clock after reset, and that rdValid is sampled as a plain level on each edge with no pulse-width requirement. They also assume that a noError result can be compared with the data field of the codeword that was present on the strobe cycle. The bench starts every input at zero before reset is released and changes inputs only on falling edges. It raises rdValid for single cycles separated by idle cycles, and in some of those idle cycles it deliberately scrambles rdCode, so the hold property sees inputs moving while no strobe is present.

// File: rtl/hamCodecPkg.sv
package hamCodecPkg;
  localparam int DATA_W = 8;
  localparam int CHK_W  = 4;
  localparam int BASE_W = DATA_W + CHK_W;

  typedef logic [DATA_W-1:0] dataWord_t;
  typedef logic [CHK_W-1:0]  chkWord_t;

  // strobes from the control decoder to the datapath
  typedef struct packed {
    logic capture;
    logic flip;
    logic noError;
    logic corrected;
    logic checkFault;
    logic uncorrectable;
  } codecStrobes_t;

  function automatic bit isPow2(int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction

  // codeword position (1-based) of data bit idx
  function automatic int dataPos(int idx);
    int cnt;
    int res;
    cnt = 0;
    res = 0;
    for (int p = 1; p <= BASE_W; p++) begin
      if (!isPow2(p)) begin
        if (cnt == idx) res = p;
        cnt++;
      end
    end
    return res;
  endfunction

  function automatic chkWord_t calcChecks(dataWord_t d);
    chkWord_t c;
    c = '0;
    for (int k = 0; k < CHK_W; k++) begin
      for (int j = 0; j < DATA_W; j++) begin
        if (((dataPos(j) >> k) & 1) == 1) c[k] = c[k] ^ d[j];
      end
    end
    return c;
  endfunction
endpackage

// File: rtl/hamEncoder.sv
module hamEncoder
  import hamCodecPkg::*;
#(
  parameter bit USE_DED = 1'b1,
  parameter int CODE_W  = BASE_W + 1
) (
  input  dataWord_t         dataIn,
  output logic [CODE_W-1:0] codeOut
);
  chkWord_t          checks;
  logic [BASE_W-1:0] baseWord;

  assign checks = calcChecks(dataIn);

  for (genvar k = 0; k < CHK_W; k++) begin : gChk
    assign baseWord[(1 << k) - 1] = checks[k];
  end

  for (genvar j = 0; j < DATA_W; j++) begin : gDat
    assign baseWord[dataPos(j) - 1] = dataIn[j];
  end

  if (USE_DED) begin : gDed
    assign codeOut = {^baseWord, baseWord};
  end else begin : gSec
    assign codeOut = baseWord;
  end
endmodule

// File: rtl/hamControl.sv
module hamControl
  import hamCodecPkg::*;
#(
  parameter bit USE_DED = 1'b1
) (
  input  logic          readStrobe,
  input  chkWord_t      syndrome,
  input  logic          parityErr,
  output codecStrobes_t strobes
);
  logic synZero;
  logic synSingle;
  logic synInRange;

  assign synZero    = (syndrome == '0);
  assign synSingle  = $onehot(syndrome);
  assign synInRange = (int'(syndrome) <= BASE_W);

  always_comb begin
    strobes         = '0;
    strobes.capture = readStrobe;
    if (USE_DED && !synZero && !parityErr) begin
      strobes.uncorrectable = 1'b1;
    end else if (synZero) begin
      if (USE_DED && parityErr) strobes.checkFault = 1'b1;
      else                      strobes.noError    = 1'b1;
    end else if (synSingle) begin
      strobes.checkFault = 1'b1;
    end else if (synInRange) begin
      strobes.corrected = 1'b1;
      strobes.flip      = 1'b1;
    end else begin
      strobes.uncorrectable = 1'b1;
    end
  end
endmodule

// File: rtl/hamDatapath.sv
module hamDatapath
  import hamCodecPkg::*;
#(
  parameter bit USE_DED = 1'b1,
  parameter int CODE_W  = BASE_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] codeIn,
  input  codecStrobes_t     strobes,
  output chkWord_t          syndrome,
  output logic              parityErr,
  output dataWord_t         dataOut,
  output logic              validOut,
  output logic              noErrorOut,
  output logic              correctedOut,
  output logic              checkFaultOut,
  output logic              uncorrectableOut
);
  dataWord_t fetched;
  dataWord_t flipMask;
  chkWord_t  storedChk;

  for (genvar j = 0; j < DATA_W; j++) begin : gFetch
    assign fetched[j]  = codeIn[dataPos(j) - 1];
    assign flipMask[j] = strobes.flip && (syndrome == CHK_W'(dataPos(j)));
  end

  for (genvar k = 0; k < CHK_W; k++) begin : gStored
    assign storedChk[k] = codeIn[(1 << k) - 1];
  end

  assign syndrome = storedChk ^ calcChecks(fetched);

  if (USE_DED) begin : gPar
    assign parityErr = ^codeIn;
  end else begin : gNoPar
    assign parityErr = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOut          <= '0;
      validOut         <= 1'b0;
      noErrorOut       <= 1'b0;
      correctedOut     <= 1'b0;
      checkFaultOut    <= 1'b0;
      uncorrectableOut <= 1'b0;
    end else begin
      validOut <= strobes.capture;
      if (strobes.capture) begin
        dataOut          <= fetched ^ flipMask;
        noErrorOut       <= strobes.noError;
        correctedOut     <= strobes.corrected;
        checkFaultOut    <= strobes.checkFault;
        uncorrectableOut <= strobes.uncorrectable;
      end
    end
  end
endmodule

// File: rtl/hamSecCodec.sv
module hamSecCodec
  import hamCodecPkg::*;
#(
  parameter bit USE_DED = 1'b1,
  localparam int CODE_W = BASE_W + (USE_DED ? 1 : 0)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        wrData,
  output logic [CODE_W-1:0] wrCode,
  input  logic              rdValid,
  input  logic [CODE_W-1:0] rdCode,
  output logic [7:0]        rdData,
  output logic              rdDone,
  output logic              noError,
  output logic              corrected,
  output logic              checkFault,
  output logic              uncorrectable
);
  codecStrobes_t strobes;
  chkWord_t      syndrome;
  logic          parityErr;

  hamEncoder #(.USE_DED(USE_DED), .CODE_W(CODE_W)) encoder (
    .dataIn (wrData),
    .codeOut(wrCode)
  );

  hamControl #(.USE_DED(USE_DED)) control (
    .readStrobe(rdValid),
    .syndrome  (syndrome),
    .parityErr (parityErr),
    .strobes   (strobes)
  );

  hamDatapath #(.USE_DED(USE_DED), .CODE_W(CODE_W)) datapath (
    .clk             (clk),
    .rstN            (rstN),
    .codeIn          (rdCode),
    .strobes         (strobes),
    .syndrome        (syndrome),
    .parityErr       (parityErr),
    .dataOut         (rdData),
    .validOut        (rdDone),
    .noErrorOut      (noError),
    .correctedOut    (corrected),
    .checkFaultOut   (checkFault),
    .uncorrectableOut(uncorrectable)
  );
endmodule

// File: rtl/hamSecCodecChecker.sv
module hamSecCodecChecker #(
  parameter bit USE_DED = 1'b1,
  parameter int CODE_W  = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic [7:0]        wrData,
  input logic [CODE_W-1:0] wrCode,
  input logic              rdValid,
  input logic [CODE_W-1:0] rdCode,
  input logic [7:0]        rdData,
  input logic              rdDone,
  input logic              noError,
  input logic              corrected,
  input logic              checkFault,
  input logic              uncorrectable
);
  logic [7:0] fieldOfRead;
  logic [3:0] flagVec;

  assign fieldOfRead = {rdCode[11:8], rdCode[6:4], rdCode[2]};
  assign flagVec     = {uncorrectable, checkFault, corrected, noError};

  assert_latency_R3: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> rdDone);

  assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |=> !rdDone);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |=> ($stable(rdData) && $stable(flagVec)));

  assert_one_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    rdDone |-> $onehot(flagVec));

  assert_enc_layout_R1: assert property (@(posedge clk) disable iff (!rstN)
    (wrCode[11:8] == wrData[7:4]) && (wrCode[6:4] == wrData[3:1]) && (wrCode[2] == wrData[0]));

  assert_clean_pass_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdDone) ##1 noError |-> rdData == $past(fieldOfRead));

  if (USE_DED) begin : gDedChk
    assert_enc_parity_R2: assert property (@(posedge clk) disable iff (!rstN)
      (^wrCode) == 1'b0);
  end
endmodule

bind hamSecCodec hamSecCodecChecker #(.USE_DED(USE_DED), .CODE_W(CODE_W)) checkerInst (
  .clk          (clk),
  .rstN         (rstN),
  .wrData       (wrData),
  .wrCode       (wrCode),
  .rdValid      (rdValid),
  .rdCode       (rdCode),
  .rdData       (rdData),
  .rdDone       (rdDone),
  .noError      (noError),
  .corrected    (corrected),
  .checkFault   (checkFault),
  .uncorrectable(uncorrectable)
);

// File: tb/hamSecCodec_test.sv
module hamSecCodec_test;
  localparam int HALF_NS = 10; // 50 MHz
  localparam logic [3:0] F_OK  = 4'b0001;
  localparam logic [3:0] F_COR = 4'b0010;
  localparam logic [3:0] F_CHK = 4'b0100;
  localparam logic [3:0] F_UNC = 4'b1000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  wrData = '0;
  logic [12:0] wrCode;
  logic        rdValid = 1'b0;
  logic [12:0] rdCode = '0;
  logic [7:0]  rdData;
  logic        rdDone, noError, corrected, checkFault, uncorrectable;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  logic [11:0] expQ[$];
  string       reqQ[$];

  always #HALF_NS clk = ~clk;

  hamSecCodec uut (
    .clk(clk), .rstN(rstN), .wrData(wrData), .wrCode(wrCode),
    .rdValid(rdValid), .rdCode(rdCode), .rdData(rdData), .rdDone(rdDone),
    .noError(noError), .corrected(corrected), .checkFault(checkFault),
    .uncorrectable(uncorrectable)
  );

  // independent reference model from the requirement equations
  function automatic logic [12:0] refEncode(logic [7:0] d);
    logic c1, c2, c4, c8;
    logic [11:0] w;
    c1 = d[0] ^ d[1] ^ d[3] ^ d[4] ^ d[6];
    c2 = d[0] ^ d[2] ^ d[3] ^ d[5] ^ d[6];
    c4 = d[1] ^ d[2] ^ d[3] ^ d[7];
    c8 = d[4] ^ d[5] ^ d[6] ^ d[7];
    w  = {d[7], d[6], d[5], d[4], c8, d[3], d[2], d[1], c4, d[0], c2, c1};
    return {^w, w};
  endfunction

  function automatic logic [7:0] refData(logic [12:0] c);
    return {c[11], c[10], c[9], c[8], c[6], c[5], c[4], c[2]};
  endfunction

  function automatic logic [12:0] flipPos(logic [12:0] c, int p);
    return c ^ (13'd1 << (p - 1));
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: push expectation, pulse rdValid, confirm the one-cycle latency
  task automatic doRead(input logic [12:0] code, input logic [7:0] expD, input logic [3:0] expF, input string req);
    @(negedge clk);
    rdCode  = code;
    rdValid = 1'b1;
    expQ.push_back({expF, expD});
    reqQ.push_back(req);
    @(negedge clk);
    rdValid = 1'b0;
    check(rdDone === 1'b1, "R3 latency", {31'd0, rdDone}, 32'd1);
  endtask

  // monitor: compare each result against the scoreboard head
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && rdDone === 1'b1) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R3 unexpected result", {31'd0, rdDone}, 32'd0);
        end else begin
          logic [11:0] e;
          string r;
          e = expQ.pop_front();
          r = reqQ.pop_front();
          check({uncorrectable, checkFault, corrected, noError, rdData} === e,
                {r, " R9 flags+data"},
                {20'd0, uncorrectable, checkFault, corrected, noError, rdData}, {20'd0, e});
        end
      end
    end
  end

  initial begin
    #(200000 * 2 * HALF_NS);
    if (!finished) begin
      nFail++;
      nChecks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] samples[8];
    int dataPositions[8];
    int chkPositions[5];
    logic [7:0]  holdD;
    logic [3:0]  holdF;
    samples = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h01, 8'h80, 8'h5A, 8'hC3};
    dataPositions = '{3, 5, 6, 7, 9, 10, 11, 12};
    chkPositions  = '{1, 2, 4, 8, 13};

    // R10: reset state
    repeat (3) @(negedge clk);
    check({rdDone, uncorrectable, checkFault, corrected, noError, rdData} === 13'd0,
          "R10 reset outputs",
          {19'd0, rdDone, uncorrectable, checkFault, corrected, noError, rdData}, 32'd0);
    rstN = 1'b1;

    // R1 / R2: encoder layout and check bits
    foreach (samples[i]) begin
      logic [12:0] e;
      @(negedge clk);
      wrData = samples[i];
      #1;
      e = refEncode(samples[i]);
      check(refData(wrCode) === samples[i], "R1 data placement", {24'd0, refData(wrCode)}, {24'd0, samples[i]});
      check({wrCode[12], wrCode[7], wrCode[3], wrCode[1], wrCode[0]} === {e[12], e[7], e[3], e[1], e[0]},
            "R2 check and parity bits", {19'd0, wrCode}, {19'd0, e});
    end

    // R4: clean words
    foreach (samples[i]) doRead(refEncode(samples[i]), samples[i], F_OK, "R4 clean");

    // R5: every single data-bit flip is corrected
    foreach (dataPositions[i]) doRead(flipPos(refEncode(8'hA5), dataPositions[i]), 8'hA5, F_COR, "R5 data flip");
    foreach (dataPositions[i]) doRead(flipPos(refEncode(8'h3C), dataPositions[i]), 8'h3C, F_COR, "R5 data flip");

    // R6: check-bit and parity-bit flips
    foreach (chkPositions[i]) doRead(flipPos(refEncode(8'h5A), chkPositions[i]), 8'h5A, F_CHK, "R6 check flip");

    // R7: double errors
    begin
      logic [12:0] c;
      c = flipPos(flipPos(refEncode(8'hC3), 3), 5);
      doRead(c, refData(c), F_UNC, "R7 double data");
      c = flipPos(flipPos(refEncode(8'hC3), 1), 12);
      doRead(c, refData(c), F_UNC, "R7 double mixed");
      c = flipPos(flipPos(refEncode(8'h81), 2), 13);
      doRead(c, refData(c), F_UNC, "R7 check plus parity");
    end

    // R8: syndromes 13, 14, 15 with odd overall parity
    doRead(flipPos(flipPos(flipPos(refEncode(8'h96), 1), 4), 8), 8'h96, F_UNC, "R8 syndrome 13");
    doRead(flipPos(flipPos(flipPos(refEncode(8'h96), 2), 4), 8), 8'h96, F_UNC, "R8 syndrome 14");
    doRead(flipPos(flipPos(flipPos(flipPos(flipPos(refEncode(8'h96), 1), 2), 4), 8), 13), 8'h96, F_UNC, "R8 syndrome 15");

    // R3: outputs hold while rdValid stays low and rdCode moves
    doRead(flipPos(refEncode(8'h3C), 6), 8'h3C, F_COR, "R3 setup");
    holdD = rdData;
    holdF = {uncorrectable, checkFault, corrected, noError};
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      rdCode = 13'h1ABC ^ 13'(n * 37);
      @(negedge clk);
      check({rdDone, holdF, holdD} === {1'b0, uncorrectable, checkFault, corrected, noError, rdData},
            "R3 hold without strobe",
            {19'd0, rdDone, uncorrectable, checkFault, corrected, noError, rdData},
            {19'd0, 1'b0, holdF, holdD});
    end

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R3 all results seen", expQ.size(), 32'd0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule